// File: doc/BRIEF.md
# JTAG Register-Bus Access Port

This block is a test access port that lets an external debugger reach a 128-entry register space of 32-bit words through the four-wire TCK/TMS/TDI/TDO interface. Behind it sits a plain synchronous register bus, clocked by TCK. The bus carries a 7-bit address, 32 bits of write data, a one-cycle write strobe, a one-cycle read strobe and read data returned in the same cycle as the read strobe.

The debugger first loads the scan-chain-select instruction and writes chain number 0 into the 5-bit chain register. It then loads the access instruction and shifts 40-bit access words. Each access word carries the data first, then the address, then a direction bit. Reads are pipelined: a scan that names an address starts the read, and the next scan shifts that register's value out. A register whose read has a side effect is therefore touched once per scan that names it. The usual way to finish a read sequence is a last scan to address 0.

Top module: `jtag_regbus_port`

## Requirements
- R1: After trst_n is asserted, bus_we, bus_re and tdo_en are low, the instruction is the all-ones bypass code and the chain number is all ones (31).
- R2: The instruction register is 4 bits, shifted LSB first, and Capture-IR loads the pattern 0001, so the first four bits shifted out are 1, 0, 0, 0.
- R3: The access word is 40 bits, LSB first: data in bits 31:0, address in bits 38:32, direction in bit 39. With bit 39 = 1, Update-DR gives exactly one TCK cycle of bus_we, carrying that address and data. bus_we and bus_re are never high together.
- R4: With bit 39 = 0, Update-DR gives one cycle of bus_re and latches bus_rdata. The next Capture-DR places that value in bits 31:0, so the following scan shifts it out.
- R5: Instruction 0x2 selects a 5-bit chain-number register. Capture-DR loads its current value and Update-DR makes the shifted value current.
- R6: A register with a read side effect is read exactly once per scan that addresses it, and a following scan to address 0 does not touch it.
- R7: Any instruction other than 0x2 and 0xC selects a 1-bit bypass register that captures 0.
- R8: The access chain is used only when the instruction is 0xC and the chain number is 0. Otherwise instruction 0xC behaves as bypass and issues no bus strobe.
- R9: All 128 addresses, including address 127, can be written and read back.
- R10: Five rising TCK edges with TMS high reach Test-Logic-Reset from any state, and that state restores the defaults of R1.
- R11: TDO is updated on the falling edge of TCK, and tdo_en is high only while the controller is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; also clocks the register bus |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Test mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | High while TDO carries shift data |
| bus_addr | output | 7 | Register address for the current strobe |
| bus_wdata | output | 32 | Write data for the current strobe |
| bus_we | output | 1 | One-cycle write strobe |
| bus_re | output | 1 | One-cycle read strobe |
| bus_rdata | input | 32 | Read data returned in the read-strobe cycle |

## Verification
The bench builds the block with its default parameters: 32 data bits, 7 address bits, a 4-bit instruction and a 5-bit chain number. With these values the full 40-bit access word is exercised, and the top address 127 tests the address field at its limit. The chain number's reset value 31 shows that a non-zero chain turns instruction 0xC into a bypass. A bench-side register at address 4 counts its own reads, so the one-read-per-scan pipelining can be seen at the ports.

// File: rtl/srp_pkg.sv
package srp_pkg;

   typedef enum logic [3:0] {
      TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PA_DR, EX2_DR, UPD_DR,
      SEL_IR, CAP_IR, SH_IR, EX1_IR, PA_IR, EX2_IR, UPD_IR
   } tap_st_e;

   function automatic tap_st_e tap_next(input tap_st_e s, input logic tms);
      tap_st_e n;
      case (s)
         TLR:     n = tms ? TLR    : RTI;
         RTI:     n = tms ? SEL_DR : RTI;
         SEL_DR:  n = tms ? SEL_IR : CAP_DR;
         CAP_DR:  n = tms ? EX1_DR : SH_DR;
         SH_DR:   n = tms ? EX1_DR : SH_DR;
         EX1_DR:  n = tms ? UPD_DR : PA_DR;
         PA_DR:   n = tms ? EX2_DR : PA_DR;
         EX2_DR:  n = tms ? UPD_DR : SH_DR;
         UPD_DR:  n = tms ? SEL_DR : RTI;
         SEL_IR:  n = tms ? TLR    : CAP_IR;
         CAP_IR:  n = tms ? EX1_IR : SH_IR;
         SH_IR:   n = tms ? EX1_IR : SH_IR;
         EX1_IR:  n = tms ? UPD_IR : PA_IR;
         PA_IR:   n = tms ? EX2_IR : PA_IR;
         EX2_IR:  n = tms ? UPD_IR : SH_IR;
         UPD_IR:  n = tms ? SEL_DR : RTI;
         default: n = TLR;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
   import srp_pkg::*;
(
   input  logic    tck,
   input  logic    trst_n,
   input  logic    tms,
   output tap_st_e state
);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state <= TLR;
      else         state <= tap_next(state, tms);
   end

   // Run of consecutive TMS-high edges, used only by the check below
   logic [2:0] hi_run;
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)            hi_run <= '0;
      else if (!tms)          hi_run <= '0;
      else if (hi_run != 3'd7) hi_run <= hi_run + 3'd1;
   end

   // R10: five TMS-high edges always land in Test-Logic-Reset
   p_tms_reset_r10: assert property (@(posedge tck) disable iff (!trst_n)
      (hi_run >= 3'd5) |-> (state == TLR));

endmodule

// File: rtl/jtag_access_chain.sv
module jtag_access_chain #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 7
) (
   input  logic              tck,
   input  logic              trst_n,
   input  logic              sel,
   input  logic              cap_en,
   input  logic              sh_en,
   input  logic              upd_en,
   input  logic              tdi,
   output logic              so,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              bus_we,
   output logic              bus_re,
   input  logic [DATA_W-1:0] bus_rdata
);

   localparam int CHAIN_W = DATA_W + ADDR_W + 1;
   localparam int RW_BIT  = CHAIN_W - 1;

   logic [CHAIN_W-1:0] sr;
   logic [DATA_W-1:0]  hold;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         sr <= '0;
      end else if (sel && cap_en) begin
         sr <= {{(ADDR_W+1){1'b0}}, hold};
      end else if (sel && sh_en) begin
         sr <= {tdi, sr[CHAIN_W-1:1]};
      end
   end

   assign bus_wdata = sr[DATA_W-1:0];
   assign bus_addr  = sr[DATA_W +: ADDR_W];
   assign bus_we    = sel && upd_en &&  sr[RW_BIT];
   assign bus_re    = sel && upd_en && !sr[RW_BIT];
   assign so        = sr[0];

   // Read result waits here for the next Capture-DR
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)     hold <= '0;
      else if (bus_re) hold <= bus_rdata;
   end

   // R3: write strobe lasts one cycle
   p_we_pulse_r3: assert property (@(posedge tck) disable iff (!trst_n)
      bus_we |=> !bus_we);
   // R4: read strobe lasts one cycle
   p_re_pulse_r4: assert property (@(posedge tck) disable iff (!trst_n)
      bus_re |=> !bus_re);
   // R4: a capture after a read presents the latched word
   p_capture_hold_r4: assert property (@(posedge tck) disable iff (!trst_n)
      (sel && cap_en) |=> (sr[DATA_W-1:0] == $past(hold)));

endmodule

// File: rtl/jtag_regbus_port.sv
module jtag_regbus_port
   import srp_pkg::*;
#(
   parameter int             DATA_W      = 32,
   parameter int             ADDR_W      = 7,
   parameter int             IR_W        = 4,
   parameter int             SEL_W       = 5,
   parameter logic [IR_W-1:0] INS_SELECT = 4'h2,
   parameter logic [IR_W-1:0] INS_ACCESS = 4'hC,
   parameter logic [IR_W-1:0] IR_CAPTURE = 4'b0001,
   parameter bit             TDO_NEGEDGE = 1'b1
) (
   input  logic              tck,
   input  logic              trst_n,
   input  logic              tms,
   input  logic              tdi,
   output logic              tdo,
   output logic              tdo_en,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              bus_we,
   output logic              bus_re,
   input  logic [DATA_W-1:0] bus_rdata
);

   localparam logic [IR_W-1:0]  INS_BYPASS = '1;
   localparam logic [SEL_W-1:0] CHAIN_DFLT = '1;
   localparam logic [SEL_W-1:0] CHAIN_ACC  = '0;

   // Elaboration-time parameter checks
   if (IR_W < 2)                   begin : g_bad_ir   $error("IR_W must be at least 2"); end
   if (INS_SELECT == INS_ACCESS)   begin : g_bad_ins  $error("instruction codes collide"); end
   if (INS_SELECT == INS_BYPASS ||
       INS_ACCESS == INS_BYPASS)   begin : g_bad_byp  $error("all-ones code is reserved for bypass"); end
   if (ADDR_W < 1 || ADDR_W > 16)  begin : g_bad_addr $error("ADDR_W out of range"); end
   if (SEL_W < 1)                  begin : g_bad_sel  $error("SEL_W must be positive"); end

   tap_st_e state;

   jtag_tap_fsm u_fsm (
      .tck    (tck),
      .trst_n (trst_n),
      .tms    (tms),
      .state  (state)
   );

   logic [IR_W-1:0]  ir_sr, ir_q;
   logic [SEL_W-1:0] ch_sr, chain_q;
   logic             byp;
   logic             sel_chain, sel_acc, acc_so;

   assign sel_chain = (ir_q == INS_SELECT);
   assign sel_acc   = (ir_q == INS_ACCESS) && (chain_q == CHAIN_ACC);

   // Instruction register
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         ir_sr <= '0;
         ir_q  <= INS_BYPASS;
      end else begin
         case (state)
            TLR:     ir_q  <= INS_BYPASS;
            CAP_IR:  ir_sr <= IR_CAPTURE;
            SH_IR:   ir_sr <= {tdi, ir_sr[IR_W-1:1]};
            UPD_IR:  ir_q  <= ir_sr;
            default: ;
         endcase
      end
   end

   // Chain-number register
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         ch_sr   <= '0;
         chain_q <= CHAIN_DFLT;
      end else if (state == TLR) begin
         chain_q <= CHAIN_DFLT;
      end else if (sel_chain) begin
         case (state)
            CAP_DR:  ch_sr   <= chain_q;
            SH_DR:   ch_sr   <= {tdi, ch_sr[SEL_W-1:1]};
            UPD_DR:  chain_q <= ch_sr;
            default: ;
         endcase
      end
   end

   // Bypass bit
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)              byp <= 1'b0;
      else if (state == CAP_DR) byp <= 1'b0;
      else if (state == SH_DR)  byp <= tdi;
   end

   jtag_access_chain #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_acc (
      .tck       (tck),
      .trst_n    (trst_n),
      .sel       (sel_acc),
      .cap_en    (state == CAP_DR),
      .sh_en     (state == SH_DR),
      .upd_en    (state == UPD_DR),
      .tdi       (tdi),
      .so        (acc_so),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_we    (bus_we),
      .bus_re    (bus_re),
      .bus_rdata (bus_rdata)
   );

   logic tdo_d, en_d;
   always_comb begin
      en_d = (state == SH_IR) || (state == SH_DR);
      if (state == SH_IR)  tdo_d = ir_sr[0];
      else if (sel_chain)  tdo_d = ch_sr[0];
      else if (sel_acc)    tdo_d = acc_so;
      else                 tdo_d = byp;
   end

   if (TDO_NEGEDGE) begin : g_tdo_fall
      always_ff @(negedge tck or negedge trst_n) begin
         if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
         end else begin
            tdo    <= tdo_d;
            tdo_en <= en_d;
         end
      end
      // R11: output enable tracks the shift states
      p_tdo_en_r11: assert property (@(posedge tck) disable iff (!trst_n)
         tdo_en |-> (state == SH_IR || state == SH_DR));
   end else begin : g_tdo_rise
      always_ff @(posedge tck or negedge trst_n) begin
         if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
         end else begin
            tdo    <= tdo_d;
            tdo_en <= en_d;
         end
      end
   end

   // R3: strobes are mutually exclusive
   p_strobe_excl_r3: assert property (@(posedge tck) disable iff (!trst_n)
      !(bus_we && bus_re));
   // R1 and R10: Test-Logic-Reset restores defaults
   p_tlr_defaults_r10: assert property (@(posedge tck) disable iff (!trst_n)
      (state == TLR) |=> (ir_q == INS_BYPASS && chain_q == CHAIN_DFLT));
   // R8: strobes only when the access chain is routed
   p_strobe_route_r8: assert property (@(posedge tck) disable iff (!trst_n)
      (bus_we || bus_re) |-> (ir_q == INS_ACCESS && chain_q == CHAIN_ACC));

endmodule

// File: tb/jtag_regbus_port_tb_top.sv
`timescale 1ns/1ps
module jtag_regbus_port_tb_top;

   logic        tck = 1'b0;
   logic        trst_n = 1'b0;
   logic        tms = 1'b1;
   logic        tdi = 1'b0;
   logic        tdo, tdo_en;
   logic [6:0]  bus_addr;
   logic [31:0] bus_wdata, bus_rdata;
   logic        bus_we, bus_re;

   always #2.5 tck = ~tck;

   jtag_regbus_port #(
      .DATA_W (32),
      .ADDR_W (7),
      .IR_W   (4),
      .SEL_W  (5)
   ) dut_i (
      .tck       (tck),
      .trst_n    (trst_n),
      .tms       (tms),
      .tdi       (tdi),
      .tdo       (tdo),
      .tdo_en    (tdo_en),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_we    (bus_we),
      .bus_re    (bus_re),
      .bus_rdata (bus_rdata)
   );

   // Register model behind the bus; address 4 counts its own reads
   logic [31:0] mem [128];
   logic [31:0] pop_cnt = 0;
   int          we_cnt = 0;
   int          re_cnt = 0;

   assign bus_rdata = (bus_addr == 7'd4) ? pop_cnt : mem[bus_addr];

   always @(posedge tck) begin
      if (bus_we) begin
         mem[bus_addr] <= bus_wdata;
         we_cnt <= we_cnt + 1;
      end
      if (bus_re) begin
         re_cnt <= re_cnt + 1;
         if (bus_addr == 7'd4) pop_cnt <= pop_cnt + 1;
      end
   end

   int checks = 0;
   int errors = 0;
   int en_bad = 0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input logic m, input logic d, output logic b);
      @(negedge tck); #1;
      tms = m;
      tdi = d;
      b = tdo;
      @(posedge tck); #1;
   endtask

   task automatic step(input logic m);
      logic b;
      tick(m, 1'b0, b);
   endtask

   task automatic tap_reset();
      repeat (5) step(1'b1);
      step(1'b0);
   endtask

   task automatic scan_ir(input logic [3:0] v, output logic [3:0] o);
      logic b;
      step(1); step(1); step(0); step(0);
      for (int i = 0; i < 4; i++) begin
         tick(i == 3, v[i], b);
         o[i] = b;
         if (tdo_en !== 1'b1) en_bad++;
      end
      step(1); step(0);
   endtask

   task automatic scan_dr(input logic [39:0] v, input int n, output logic [39:0] o);
      logic b;
      o = '0;
      step(1); step(0); step(0);
      for (int i = 0; i < n; i++) begin
         tick(i == n - 1, v[i], b);
         o[i] = b;
         if (tdo_en !== 1'b1) en_bad++;
      end
      step(1); step(0);
   endtask

   task automatic acc(input logic rw, input logic [6:0] a, input logic [31:0] d,
                      output logic [31:0] dout);
      logic [39:0] o;
      scan_dr({rw, a, d}, 40, o);
      dout = o[31:0];
   endtask

   task automatic set_chain(input logic [4:0] c);
      logic [3:0]  io;
      logic [39:0] o;
      scan_ir(4'h2, io);
      scan_dr({35'd0, c}, 5, o);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      chk("R1 tdo_en low in reset", {63'd0, tdo_en}, 64'd0);
      chk("R1 strobes low in reset", {62'd0, bus_we, bus_re}, 64'd0);
   endtask

   task automatic t_ir_capture();
      logic [3:0]  io;
      logic [39:0] o;
      scan_ir(4'hF, io);
      chk("R2 IR capture pattern", {60'd0, io}, 64'h1);
      scan_dr(40'h3, 2, o);   // default instruction is bypass (R1, R7)
      chk("R1 R7 bypass after reset", {62'd0, o[1:0]}, 64'b10);
   endtask

   task automatic t_chain_sel();
      logic [3:0]  io;
      logic [39:0] o;
      scan_ir(4'h2, io);
      scan_dr(40'd0, 5, o);
      chk("R5 R1 chain reset value", {59'd0, o[4:0]}, 64'h1F);
      scan_dr(40'd0, 5, o);
      chk("R5 chain readback", {59'd0, o[4:0]}, 64'h0);
   endtask

   task automatic t_write();
      logic [3:0]  io;
      logic [31:0] d;
      int          w0, r0;
      scan_ir(4'hC, io);
      acc(1'b1, 7'd0, 32'hA5A5_0000, d);
      w0 = we_cnt; r0 = re_cnt;
      acc(1'b1, 7'd5, 32'h1234_5678, d);
      chk("R3 write data", {32'd0, mem[5]}, {32'd0, 32'h1234_5678});
      chk("R3 one write strobe", 64'(we_cnt - w0), 64'd1);
      chk("R3 no read strobe on write", 64'(re_cnt - r0), 64'd0);
      acc(1'b1, 7'd127, 32'hCAFE_F00D, d);
      chk("R9 write top address", {32'd0, mem[127]}, {32'd0, 32'hCAFE_F00D});
   endtask

   task automatic t_read();
      logic [31:0] d;
      acc(1'b0, 7'd5, 32'd0, d);
      acc(1'b0, 7'd0, 32'd0, d);
      chk("R4 pipelined read", {32'd0, d}, {32'd0, 32'h1234_5678});
      acc(1'b0, 7'd127, 32'd0, d);
      acc(1'b0, 7'd0, 32'd0, d);
      chk("R9 read top address", {32'd0, d}, {32'd0, 32'hCAFE_F00D});
   endtask

   task automatic t_side_effect();
      logic [31:0] d;
      logic [31:0] p0;
      p0 = pop_cnt;
      acc(1'b0, 7'd4, 32'd0, d);
      acc(1'b0, 7'd0, 32'd0, d);
      chk("R6 first counted read", {32'd0, d}, {32'd0, p0});
      chk("R6 single touch", {32'd0, pop_cnt}, {32'd0, p0 + 32'd1});
      acc(1'b0, 7'd4, 32'd0, d);
      acc(1'b0, 7'd4, 32'd0, d);
      chk("R6 back-to-back value", {32'd0, d}, {32'd0, p0 + 32'd1});
      acc(1'b0, 7'd0, 32'd0, d);
      chk("R6 last value", {32'd0, d}, {32'd0, p0 + 32'd2});
      chk("R6 touch count", {32'd0, pop_cnt}, {32'd0, p0 + 32'd3});
   endtask

   task automatic t_route();
      logic [3:0]  io;
      logic [39:0] o;
      int          w0;
      set_chain(5'd3);
      scan_ir(4'hC, io);
      w0 = we_cnt;
      scan_dr({1'b1, 7'd5, 32'h0000_DEAD}, 40, o);
      chk("R8 no strobe off chain 0", 64'(we_cnt - w0), 64'd0);
      chk("R8 register untouched", {32'd0, mem[5]}, {32'd0, 32'h1234_5678});
      chk("R8 acts as bypass", {62'd0, o[1:0]}, 64'b10);
      scan_ir(4'h5, io);
      scan_dr(40'h1, 2, o);
      chk("R7 unassigned code bypass", {62'd0, o[1:0]}, 64'b10);
   endtask

   task automatic t_tlr();
      logic [3:0]  io;
      logic [39:0] o;
      scan_ir(4'h2, io);
      step(1); step(0); step(0); step(0);   // park in Shift-DR
      tap_reset();
      scan_dr(40'h3, 2, o);
      chk("R10 instruction back to bypass", {62'd0, o[1:0]}, 64'b10);
      scan_ir(4'h2, io);
      scan_dr(40'd0, 5, o);
      chk("R10 chain back to ones", {59'd0, o[4:0]}, 64'h1F);
   endtask

   task automatic t_tdo_en();
      step(0);
      chk("R11 tdo_en low in idle", {63'd0, tdo_en}, 64'd0);
      chk("R11 tdo_en high in every shift bit", 64'(en_bad), 64'd0);
   endtask

   initial begin
      repeat (3) @(posedge tck);
      #1;
      t_reset();
      trst_n = 1'b1;
      tap_reset();
      t_ir_capture();
      t_chain_sel();
      t_write();
      t_read();
      t_side_effect();
      t_route();
      t_tlr();
      t_tdo_en();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge tck);
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule